// File: doc/BRIEF.md
# RT-to-RT Receive No-Response Timer

This block watches one RT-to-RT receive exchange on a command/response serial bus. When the receiving terminal accepts an RT-to-RT receive command, the block starts timing. It waits for the transmitting terminal to start its reply. If the reply's first valid sync does not arrive within the selected window, the block raises a one-cycle no-response error and returns to idle. If the sync does arrive in time, timing stops quietly.

The window comes from a 2-bit selection register that the host can write and read back. The four settings give 57, 100, 125 and 150 µs. The 57 µs value lies inside the 54–60 µs range the bus standard requires. The longer values suit long cable runs or buses with repeaters. Only master reset clears the selection; software reset leaves it unchanged. Time is counted in 1 µs steps from a prescaler driven by the system clock, and the clock frequency is a parameter.

Top module: `rtrt_nresp_timer`

## Requirements
- R1: The selection register's encoding sets the window: 2'b00 gives 57 µs, 2'b01 gives 100 µs, 2'b10 gives 125 µs and 2'b11 gives 150 µs.
- R2: Master reset sets the selection to 2'b00 and clears the busy flag and the error output.
- R3: A host write (write enable high at a clock edge) loads the selection, and the read port shows the new value from the next cycle.
- R4: Software reset stops any timing in progress without raising an error, and it does not change the selection.
- R5: Timing starts at the clock edge where the command strobe is high. The busy flag is high from the next cycle.
- R6: With window W µs and CLK_HZ/1e6 clock cycles per µs (C), the error goes high exactly W*C cycles after the start edge. It stays high for one cycle, and busy falls in the same cycle.
- R7: A valid-sync strobe while busy stops timing with no error. This includes the cycle in which the window would otherwise expire.
- R8: The selection is captured at the start edge. A write during timing affects only the next exchange.
- R9: A command strobe while busy restarts the full window from that edge.
- R10: A valid-sync strobe while idle has no effect: busy stays low and no error appears.
- R11: After an error the block stays idle (no further error, busy low) until the next command strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| mreset | input | 1 | Master reset, synchronous, active high |
| sreset | input | 1 | Software reset, synchronous, active high |
| cfg_we | input | 1 | Host write enable for the selection register |
| cfg_wdata | input | 2 | Host write data for the selection |
| cfg_rdata | output | 2 | Current selection value |
| rtrt_cmd_acc | input | 1 | Strobe: RT-to-RT receive command accepted |
| rx_sync_ok | input | 1 | Strobe: valid sync from the transmitting terminal |
| nr_timeout | output | 1 | One-cycle no-response error pulse |
| nr_busy | output | 1 | High while timing is in progress |

## Verification
Checked on every cycle:
- the error is one cycle wide and only follows a busy cycle;
- busy only rises after a command strobe;
- a sync strobe while busy ends timing with no error;
- the microsecond count never passes the captured window;
- master reset clears the selection, and software reset leaves it unchanged.

Only the bench scenarios show the rest:
- the exact expiry cycle for each of the four encodings;
- the selection being captured at the start edge;
- a restart while busy;
- the sync strobe winning in the expiry cycle.

// File: rtl/rtrt_nresp_pkg.sv
package rtrt_nresp_pkg;
  typedef enum logic [1:0] {
    WIN_STD   = 2'b00,
    WIN_MID   = 2'b01,
    WIN_LONG  = 2'b10,
    WIN_XLONG = 2'b11
  } win_sel_t;

  localparam int unsigned HZ_PER_MHZ = 1_000_000;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/rtrt_us_prescaler.sv
module rtrt_us_prescaler #(
  parameter int unsigned CYC_PER_US = 50
) (
  input  logic clk,
  input  logic clr,
  input  logic run,
  output logic us_tick
);
  localparam int unsigned PW = (CYC_PER_US > 1) ? $clog2(CYC_PER_US) : 1;
  localparam logic [PW-1:0] LAST = PW'(CYC_PER_US - 1);

  logic [PW-1:0] cnt_q;

  assign us_tick = run && !clr && (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (clr || !run) cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end

  AST_PRESC_RANGE: assert property (@(posedge clk) cnt_q <= LAST) else $error("prescaler range"); // R6
endmodule

// File: rtl/rtrt_win_select.sv
module rtrt_win_select
  import rtrt_nresp_pkg::*;
#(
  parameter int unsigned US_STD   = 57,
  parameter int unsigned US_MID   = 100,
  parameter int unsigned US_LONG  = 125,
  parameter int unsigned US_XLONG = 150,
  parameter int unsigned UW       = 8
) (
  input  logic          clk,
  input  logic          mreset,
  input  logic          we,
  input  logic [1:0]    wdata,
  output logic [1:0]    sel,
  output logic [UW-1:0] win_us
);
  win_sel_t sel_q;

  always_ff @(posedge clk) begin
    if (mreset) sel_q <= WIN_STD;
    else if (we) sel_q <= win_sel_t'(wdata);
  end

  assign sel = sel_q;

  always_comb begin
    unique case (sel_q)
      WIN_STD:   win_us = UW'(US_STD);
      WIN_MID:   win_us = UW'(US_MID);
      WIN_LONG:  win_us = UW'(US_LONG);
      WIN_XLONG: win_us = UW'(US_XLONG);
      default:   win_us = UW'(US_STD);
    endcase
  end

  AST_SEL_MRST_CLEARS: assert property (@(posedge clk) $past(mreset) |-> (sel_q == WIN_STD)) else $error("sel mreset"); // R2
  AST_SEL_HOLDS: assert property (@(posedge clk) disable iff (mreset)
    (!$past(mreset) && !$past(we)) |-> $stable(sel_q)) else $error("sel hold"); // R4
endmodule

// File: rtl/rtrt_nresp_core.sv
module rtrt_nresp_core #(
  parameter int unsigned UW = 8
) (
  input  logic          clk,
  input  logic          mreset,
  input  logic          sreset,
  input  logic          start,
  input  logic          sync_ok,
  input  logic [UW-1:0] win_us,
  input  logic          us_tick,
  output logic          busy,
  output logic          timeout
);
  logic [UW-1:0] lim_q;
  logic [UW-1:0] us_q;
  logic          busy_q;
  logic          to_q;
  logic          expire;

  assign expire = busy_q && us_tick && (us_q == lim_q - 1'b1);

  always_ff @(posedge clk) begin
    if (mreset || sreset) begin
      busy_q <= 1'b0;
      to_q   <= 1'b0;
      us_q   <= '0;
      lim_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      to_q   <= 1'b0;
      us_q   <= '0;
      lim_q  <= win_us;
    end else if (busy_q && sync_ok) begin
      busy_q <= 1'b0;
      to_q   <= 1'b0;
    end else if (expire) begin
      busy_q <= 1'b0;
      to_q   <= 1'b1;
    end else begin
      to_q <= 1'b0;
      if (busy_q && us_tick) us_q <= us_q + 1'b1;
    end
  end

  assign busy    = busy_q;
  assign timeout = to_q;

  AST_ERR_ONE_CYCLE: assert property (@(posedge clk) disable iff (mreset || sreset)
    to_q |=> !to_q) else $error("err width"); // R6
  AST_ERR_AFTER_BUSY: assert property (@(posedge clk) disable iff (mreset || sreset)
    $rose(to_q) |-> ($past(busy_q) && !busy_q)) else $error("err w/o busy"); // R11
  AST_BUSY_NEEDS_CMD: assert property (@(posedge clk) disable iff (mreset || sreset)
    $rose(busy_q) |-> $past(start)) else $error("busy w/o cmd"); // R5
  AST_SYNC_STOPS: assert property (@(posedge clk) disable iff (mreset || sreset)
    (busy_q && sync_ok && !start) |=> (!busy_q && !to_q)) else $error("sync stop"); // R7
  AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (mreset || sreset)
    busy_q |-> (us_q < lim_q)) else $error("count overrun"); // R6
endmodule

// File: rtl/rtrt_nresp_timer.sv
module rtrt_nresp_timer
  import rtrt_nresp_pkg::*;
#(
  parameter int unsigned CLK_HZ   = 50_000_000,
  parameter int unsigned US_STD   = 57,
  parameter int unsigned US_MID   = 100,
  parameter int unsigned US_LONG  = 125,
  parameter int unsigned US_XLONG = 150
) (
  input  logic       clk,
  input  logic       mreset,
  input  logic       sreset,
  input  logic       cfg_we,
  input  logic [1:0] cfg_wdata,
  output logic [1:0] cfg_rdata,
  input  logic       rtrt_cmd_acc,
  input  logic       rx_sync_ok,
  output logic       nr_timeout,
  output logic       nr_busy
);
  localparam int unsigned CYC_PER_US = CLK_HZ / HZ_PER_MHZ;
  localparam int unsigned MAX_US     = max4(US_STD, US_MID, US_LONG, US_XLONG);
  localparam int unsigned UW         = $clog2(MAX_US + 1);

  logic [UW-1:0] win_us;
  logic          us_tick;
  logic          busy_w;

  rtrt_win_select #(
    .US_STD(US_STD), .US_MID(US_MID), .US_LONG(US_LONG), .US_XLONG(US_XLONG), .UW(UW)
  ) u_sel (
    .clk(clk), .mreset(mreset), .we(cfg_we), .wdata(cfg_wdata),
    .sel(cfg_rdata), .win_us(win_us)
  );

  rtrt_us_prescaler #(.CYC_PER_US(CYC_PER_US)) u_presc (
    .clk(clk), .clr(rtrt_cmd_acc || mreset || sreset), .run(busy_w), .us_tick(us_tick)
  );

  rtrt_nresp_core #(.UW(UW)) u_core (
    .clk(clk), .mreset(mreset), .sreset(sreset), .start(rtrt_cmd_acc),
    .sync_ok(rx_sync_ok), .win_us(win_us), .us_tick(us_tick),
    .busy(busy_w), .timeout(nr_timeout)
  );

  assign nr_busy = busy_w;
endmodule

// File: tb/rtrt_nresp_timer_tb_top.sv
`timescale 1ns/1ps
module rtrt_nresp_timer_tb_top;
  localparam int C = 50;

  logic clk = 1'b0;
  logic mreset = 1'b1, sreset = 1'b0, cfg_we = 1'b0, cmd = 1'b0, sync = 1'b0;
  logic [1:0] wdata = 2'b00;
  logic [1:0] rdata;
  logic to, busy;
  int checks = 0, fails = 0;
  bit  done = 1'b0;

  always #10 clk = ~clk;

  rtrt_nresp_timer dut_i (
    .clk(clk), .mreset(mreset), .sreset(sreset), .cfg_we(cfg_we), .cfg_wdata(wdata),
    .cfg_rdata(rdata), .rtrt_cmd_acc(cmd), .rx_sync_ok(sync),
    .nr_timeout(to), .nr_busy(busy)
  );

  function automatic int win_of(input logic [1:0] s);
    case (s)
      2'b00: return 57;
      2'b01: return 100;
      2'b10: return 125;
      default: return 150;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_sel(input logic [1:0] v);
    cfg_we = 1'b1; wdata = v; cyc(1); cfg_we = 1'b0;
  endtask

  task automatic start_cmd();
    cmd = 1'b1; cyc(1); cmd = 1'b0;
  endtask

  task automatic t_reset();
    cyc(2); mreset = 1'b0;
    chk(rdata == 2'b00, "R2 sel after mreset", rdata, 0);
    chk(busy == 1'b0 && to == 1'b0, "R2 outputs idle", {busy, to}, 0);
  endtask

  task automatic t_rw();
    wr_sel(2'b10);
    chk(rdata == 2'b10, "R3 readback", rdata, 2);
    wr_sel(2'b01);
    chk(rdata == 2'b01, "R3 readback", rdata, 1);
  endtask

  task automatic t_timeout(input logic [1:0] s);
    int n;
    wr_sel(s);
    n = win_of(s) * C;
    start_cmd();
    chk(busy == 1'b1, "R5 busy after cmd", busy, 1);
    cyc(n - 1);
    chk(to == 1'b0 && busy == 1'b1, "R1 no early expiry", {busy, to}, 2);
    cyc(1);
    chk(to == 1'b1 && busy == 1'b0, "R1 R6 expiry cycle", {busy, to}, 1);
    cyc(1);
    chk(to == 1'b0, "R6 one-cycle pulse", to, 0);
    cyc(200);
    chk(to == 1'b0 && busy == 1'b0, "R11 stays idle", {busy, to}, 0);
  endtask

  task automatic t_sync_stop();
    wr_sel(2'b00);
    start_cmd(); cyc(500);
    sync = 1'b1; cyc(1); sync = 1'b0;
    chk(busy == 1'b0 && to == 1'b0, "R7 sync stops", {busy, to}, 0);
    cyc(57 * C);
    chk(to == 1'b0, "R7 no late error", to, 0);
  endtask

  task automatic t_sync_at_expiry();
    bit seen = 1'b0;
    wr_sel(2'b00);
    start_cmd(); cyc(57 * C - 1);
    sync = 1'b1; cyc(1); sync = 1'b0;
    chk(busy == 1'b0 && to == 1'b0, "R7 sync wins at expiry", {busy, to}, 0);
    for (int i = 0; i < 10; i++) begin cyc(1); if (to) seen = 1'b1; end
    chk(!seen, "R7 no error after", seen, 0);
  endtask

  task automatic t_sreset();
    wr_sel(2'b11);
    start_cmd(); cyc(300);
    sreset = 1'b1; cyc(1); sreset = 1'b0;
    chk(busy == 1'b0 && to == 1'b0, "R4 sreset aborts", {busy, to}, 0);
    chk(rdata == 2'b11, "R4 sel kept", rdata, 3);
    cyc(150 * C);
    chk(to == 1'b0, "R4 no error later", to, 0);
  endtask

  task automatic t_midwrite();
    wr_sel(2'b00);
    start_cmd(); cyc(100);
    wr_sel(2'b11);
    cyc(57 * C - 102);
    chk(to == 1'b0, "R8 pre-expiry", to, 0);
    cyc(1);
    chk(to == 1'b1, "R8 captured window used", to, 1);
    cyc(1);
    start_cmd(); cyc(150 * C - 1);
    chk(to == 1'b0, "R8 next msg new window", to, 0);
    cyc(1);
    chk(to == 1'b1, "R8 next msg expiry", to, 1);
    cyc(2);
  endtask

  task automatic t_restart();
    wr_sel(2'b00);
    start_cmd(); cyc(1000);
    start_cmd();
    cyc(57 * C - 1);
    chk(to == 1'b0 && busy == 1'b1, "R9 restarted window", {busy, to}, 2);
    cyc(1);
    chk(to == 1'b1, "R9 expiry from restart", to, 1);
    cyc(2);
  endtask

  task automatic t_idle_sync();
    sync = 1'b1; cyc(1); sync = 1'b0;
    chk(busy == 1'b0 && to == 1'b0, "R10 idle sync ignored", {busy, to}, 0);
    cyc(5);
    chk(busy == 1'b0 && to == 1'b0, "R10 still idle", {busy, to}, 0);
  endtask

  task automatic t_mreset_mid();
    wr_sel(2'b10);
    start_cmd(); cyc(200);
    mreset = 1'b1; cyc(1); mreset = 1'b0;
    chk(rdata == 2'b00 && busy == 1'b0, "R2 mreset mid-message", {rdata, busy}, 0);
    cyc(125 * C);
    chk(to == 1'b0, "R2 no error after mreset", to, 0);
  endtask

  initial begin
    t_reset();
    t_rw();
    t_timeout(2'b00);
    t_timeout(2'b01);
    t_timeout(2'b10);
    t_timeout(2'b11);
    t_sync_stop();
    t_sync_at_expiry();
    t_sreset();
    t_midwrite();
    t_restart();
    t_idle_sync();
    t_mreset_mid();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150_000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule